// File: doc/BRIEF.md
# Merged Interrupt Status Controller

This block gathers the event sources of a packet controller into one six-bit status word, gates that word with a software-written enable mask, and drives a single registered interrupt line. Some status bits come straight from queue states and clear themselves when the queue state changes. The receive-pending bit and the transmit-done-pending bit work this way. Other bits latch a strobe and hold it until software clears them through an acknowledge write. These are the transmit-queue-empty bit, the allocation-done bit and the receive-overrun bit.

A group of external status events, such as link or counter events, is latched bit by bit in its own flag register. That group shows up in the status word only as one summary bit. Each flag in the group is cleared by its own clear strobe. Software sees the status word, the mask and the group flags on output ports. It writes the mask and the acknowledge word through write-enable and data pairs.

Bit positions in the status, mask and acknowledge words: 0 receive pending, 1 transmit done pending, 2 transmit queue empty, 3 allocation done, 4 receive overrun, 5 external group summary.

Top module: `irq_status_ctrl`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `status`, `mask`, `grp_flags` and `irq` are all zero.
- R2: Status bit 0 equals `rx_pending` from the previous cycle. An acknowledge write has no effect on it.
- R3: Status bit 1 equals `txdone_pending` from the previous cycle. An acknowledge write has no effect on it.
- R4: Status bit 2 is set in the cycle after `txq_empty` is high. It stays set until an acknowledge write with bit 2 = 1 occurs in a cycle where `txq_empty` is low.
- R5: Status bit 3 is set in the cycle after an `alloc_evt` pulse. It is cleared in the cycle after an acknowledge write with bit 2 replaced by bit 3 = 1.
- R6: Status bit 4 is set in the cycle after an `ovrn_evt` pulse. It is cleared in the cycle after an acknowledge write with bit 4 = 1.
- R7: When a set condition and a clear condition for the same latched bit occur in one cycle, the bit ends up set.
- R8: `grp_flags[k]` is set the cycle after `grp_evt[k]` and cleared the cycle after `grp_clr[k]`, with set winning. Status bit 5 is the OR of `grp_flags`.
- R9: A cycle with `mask_we` high loads `mask_wdata` into `mask` for the next cycle. Otherwise `mask` holds.
- R10: `irq` equals the OR over all bits of `status & mask` taken one cycle earlier.
- R11: Acknowledge bits written as 0 leave the corresponding latched bits unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_pending | input | 1 | Receive queue not empty (level) |
| txdone_pending | input | 1 | Transmit completion queue not empty (level) |
| txq_empty | input | 1 | Transmit queue empty (level, latched into bit 2) |
| alloc_evt | input | 1 | Allocation completed strobe |
| ovrn_evt | input | 1 | Receive allocation failure strobe |
| grp_evt | input | GRP_W | External group event strobes |
| grp_clr | input | GRP_W | Per-flag clear strobes for the external group |
| mask_we | input | 1 | Mask write enable |
| mask_wdata | input | 6 | Mask write data |
| ack_we | input | 1 | Acknowledge write enable |
| ack_wdata | input | 6 | Acknowledge write data, 1 clears a latched bit |
| status | output | 6 | Status word |
| mask | output | 6 | Current mask |
| grp_flags | output | GRP_W | Latched external group flags |
| irq | output | 1 | Merged interrupt, registered |

## Verification
The bench keeps a model of the status word, the mask and the group flags. It runs a long pseudo-random sweep in which every input pattern, mask value and acknowledge combination appears. It also runs directed cases for a collision between a set and a clear, for acknowledge writes to the level bits, and for acknowledge writes with zero bits.

Each of these catches a specific defect:
- A design where the clear beats the set would drop an event that arrives during an acknowledge.
- A design that lets the acknowledge reach bits 0 or 1 would lose pending receive or transmit-done state.
- A design that decodes acknowledge bits wrongly would clear the wrong latch.
- A design that makes `irq` combinational, or delays it by two cycles, would be off by a cycle against the model.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int NSRC    = 6;
  localparam int B_RCV   = 0;
  localparam int B_TXD   = 1;
  localparam int B_TXE   = 2;
  localparam int B_ALLOC = 3;
  localparam int B_OVRN  = 4;
  localparam int B_GRP   = 5;
  localparam int NLATCH  = 3;
endpackage

// File: rtl/irq_latch_bits.sv
module irq_latch_bits #(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] set,
  input  logic [W-1:0] clr,
  output logic [W-1:0] q
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst)         q[i] <= 1'b0;
      else if (set[i]) q[i] <= 1'b1;
      else if (clr[i]) q[i] <= 1'b0;
    end

    assert_set_wins_R7: assert property (@(posedge clk) disable iff (rst)
      set[i] |=> q[i]);
    assert_clear_R11: assert property (@(posedge clk) disable iff (rst)
      (!set[i] && clr[i]) |=> !q[i]);
    assert_hold_R11: assert property (@(posedge clk) disable iff (rst)
      (!set[i] && !clr[i]) |=> $stable(q[i]));
  end
endmodule

// File: rtl/irq_grp_summary.sv
module irq_grp_summary #(
  parameter int GRP_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [GRP_W-1:0] evt,
  input  logic [GRP_W-1:0] clr,
  output logic [GRP_W-1:0] flags,
  output logic             any
);
  irq_latch_bits #(.W(GRP_W)) u_flags (
    .clk(clk), .rst(rst), .set(evt), .clr(clr), .q(flags)
  );

  assign any = |flags;

  assert_grp_set_R8: assert property (@(posedge clk) disable iff (rst)
    (|evt) |=> any);
endmodule

// File: rtl/irq_merge.sv
module irq_merge #(
  parameter int N = 6
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         mask_we,
  input  logic [N-1:0] mask_wdata,
  input  logic [N-1:0] status,
  output logic [N-1:0] mask,
  output logic         irq
);
  logic [N-1:0] gated;

  always_ff @(posedge clk) begin
    if (rst)          mask <= '0;
    else if (mask_we) mask <= mask_wdata;
  end

  assign gated = status & mask;

  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= |gated;
  end

  assert_mask_load_R9: assert property (@(posedge clk) disable iff (rst)
    mask_we |=> (mask == $past(mask_wdata)));
  assert_mask_hold_R9: assert property (@(posedge clk) disable iff (rst)
    !mask_we |=> $stable(mask));
  assert_irq_lag_R10: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (irq == $past(|(status & mask))));
endmodule

// File: rtl/irq_status_ctrl.sv
module irq_status_ctrl #(
  parameter int GRP_W = 4
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      rx_pending,
  input  logic                      txdone_pending,
  input  logic                      txq_empty,
  input  logic                      alloc_evt,
  input  logic                      ovrn_evt,
  input  logic [GRP_W-1:0]          grp_evt,
  input  logic [GRP_W-1:0]          grp_clr,
  input  logic                      mask_we,
  input  logic [irq_pkg::NSRC-1:0]  mask_wdata,
  input  logic                      ack_we,
  input  logic [irq_pkg::NSRC-1:0]  ack_wdata,
  output logic [irq_pkg::NSRC-1:0]  status,
  output logic [irq_pkg::NSRC-1:0]  mask,
  output logic [GRP_W-1:0]          grp_flags,
  output logic                      irq
);
  import irq_pkg::*;

  logic                rcv_q, txd_q;
  logic [NLATCH-1:0]   lat_set, lat_clr, lat_q;
  logic                grp_any;
  logic                unused_ack;

  always_ff @(posedge clk) begin
    if (rst) begin
      rcv_q <= 1'b0;
      txd_q <= 1'b0;
    end else begin
      rcv_q <= rx_pending;
      txd_q <= txdone_pending;
    end
  end

  assign lat_set = {ovrn_evt, alloc_evt, txq_empty};
  assign lat_clr = {NLATCH{ack_we}} & ack_wdata[B_OVRN:B_TXE];
  assign unused_ack = ^{ack_wdata[B_RCV], ack_wdata[B_TXD], ack_wdata[B_GRP]};

  irq_latch_bits #(.W(NLATCH)) u_lat (
    .clk(clk), .rst(rst), .set(lat_set), .clr(lat_clr), .q(lat_q)
  );

  irq_grp_summary #(.GRP_W(GRP_W)) u_grp (
    .clk(clk), .rst(rst), .evt(grp_evt), .clr(grp_clr),
    .flags(grp_flags), .any(grp_any)
  );

  assign status = {grp_any, lat_q, txd_q, rcv_q};

  irq_merge #(.N(NSRC)) u_merge (
    .clk(clk), .rst(rst), .mask_we(mask_we), .mask_wdata(mask_wdata),
    .status(status), .mask(mask), .irq(irq)
  );

  assert_rcv_level_R2: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (status[B_RCV] == $past(rx_pending)));
  assert_txd_level_R3: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (status[B_TXD] == $past(txdone_pending)));
  assert_txe_sticky_R4: assert property (@(posedge clk) disable iff (rst)
    txq_empty |=> status[B_TXE]);
  assert_alloc_set_R5: assert property (@(posedge clk) disable iff (rst)
    alloc_evt |=> status[B_ALLOC]);
  assert_ovrn_set_R6: assert property (@(posedge clk) disable iff (rst)
    ovrn_evt |=> status[B_OVRN]);
endmodule

// File: tb/sim_irq_status_ctrl.sv
`timescale 1ns/1ps
module sim_irq_status_ctrl;
  localparam int GW = 4;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic rx_pending = 0, txdone_pending = 0, txq_empty = 0, alloc_evt = 0, ovrn_evt = 0;
  logic [GW-1:0] grp_evt = '0, grp_clr = '0;
  logic mask_we = 0, ack_we = 0;
  logic [5:0] mask_wdata = '0, ack_wdata = '0;
  logic [5:0] status, mask;
  logic [GW-1:0] grp_flags;
  logic irq;

  int total = 0, bad = 0;
  logic [5:0] e_st = '0, e_mask = '0;
  logic [GW-1:0] e_grp = '0;
  logic e_irq = 1'b0;

  always #5 clk = ~clk;

  irq_status_ctrl #(.GRP_W(GW)) u0 (
    .clk(clk), .rst(rst), .rx_pending(rx_pending), .txdone_pending(txdone_pending),
    .txq_empty(txq_empty), .alloc_evt(alloc_evt), .ovrn_evt(ovrn_evt),
    .grp_evt(grp_evt), .grp_clr(grp_clr), .mask_we(mask_we), .mask_wdata(mask_wdata),
    .ack_we(ack_we), .ack_wdata(ack_wdata), .status(status), .mask(mask),
    .grp_flags(grp_flags), .irq(irq)
  );

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // one clock: update the model from the requirements, then compare at negedge
  task automatic cyc();
    logic [5:0] ack;
    @(posedge clk);
    ack = ack_we ? ack_wdata : 6'h0;
    e_irq = |(e_st & e_mask);                                            // R10
    if (mask_we) e_mask = mask_wdata;                                    // R9
    e_grp = grp_evt | (e_grp & ~grp_clr);                                // R8
    e_st[0] = rx_pending;                                                // R2
    e_st[1] = txdone_pending;                                            // R3
    e_st[2] = txq_empty | (e_st[2] & ~ack[2]);                           // R4
    e_st[3] = alloc_evt | (e_st[3] & ~ack[3]);                           // R5
    e_st[4] = ovrn_evt  | (e_st[4] & ~ack[4]);                           // R6
    e_st[5] = |e_grp;                                                    // R8
    @(negedge clk);
    chk("R2", status[0], e_st[0]);
    chk("R3", status[1], e_st[1]);
    chk("R4", status[2], e_st[2]);
    chk("R5", status[3], e_st[3]);
    chk("R6", status[4], e_st[4]);
    chk("R8", status[5], e_st[5]);
    chk("R8", grp_flags, e_grp);
    chk("R9", mask, e_mask);
    chk("R10", irq, e_irq);
  endtask

  task automatic idle();
    {rx_pending, txdone_pending, txq_empty, alloc_evt, ovrn_evt} = '0;
    grp_evt = '0; grp_clr = '0; mask_we = 0; ack_we = 0;
  endtask

  initial begin
    #2_000_000;
    bad++; total++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", status, 0); chk("R1", mask, 0); chk("R1", irq, 0); chk("R1", grp_flags, 0);
    rst = 1'b0;
    cyc();
    chk("R1", status, 0); chk("R1", irq, 0);

    // R7: set and clear of latched bits in the same cycle, set wins
    txq_empty = 1; alloc_evt = 1; ovrn_evt = 1; ack_we = 1; ack_wdata = 6'h3F;
    grp_evt = 4'h5; grp_clr = 4'hF;
    cyc();
    chk("R7", status[4:2], 3'b111); chk("R7", grp_flags, 4'h5);
    idle();
    // R11: zero ack bits leave latches
    ack_we = 1; ack_wdata = 6'h23;
    cyc();
    chk("R11", status[4:2], 3'b111);
    // R2/R3: ack of level bits has no effect
    idle(); rx_pending = 1; txdone_pending = 1; ack_we = 1; ack_wdata = 6'h03;
    cyc(); cyc();
    chk("R2", status[0], 1); chk("R3", status[1], 1);
    // clear individual latches
    idle(); ack_we = 1; ack_wdata = 6'h08; cyc();
    chk("R5", status[3], 0); chk("R11", status[4], 1);
    idle(); ack_we = 1; ack_wdata = 6'h14; cyc();
    chk("R6", status[4], 0); chk("R4", status[2], 0);
    idle(); grp_clr = 4'h1; cyc();
    chk("R8", grp_flags, 4'h4);
    idle(); grp_clr = 4'h4; cyc();
    chk("R8", status[5], 0);

    // sweep
    for (int i = 0; i < 4096; i++) begin
      int h;
      h = (i * 2654435 + 12345) ^ (i >> 3);
      rx_pending     = h[0];
      txdone_pending = h[1];
      txq_empty      = h[2] & h[3];
      alloc_evt      = (h[4:6] == 3'd0);
      ovrn_evt       = (h[7:9] == 3'd1);
      grp_evt        = h[10] ? (4'h1 << h[12:11]) : 4'h0;
      grp_clr        = h[13] ? h[17:14] : 4'h0;
      mask_we        = (h[20:18] == 3'd2);
      mask_wdata     = 6'(i >> 2);
      ack_we         = h[21];
      ack_wdata      = h[27:22];
      cyc();
    end
    idle();
    cyc();

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule